// File: doc/BRIEF.md
# Bitfield Move Execution Unit

This unit performs the bitfield move operations of a load/store RISC core on 32-bit or 64-bit operands. A source operand is rotated right by an amount R, and a top-bit index S says where the field ends. When S is at least R, source bits S down to R become a right-aligned field. When S is below R, the low S+1 source bits are deposited at bit position (size − R) mod size. Three fill policies share one datapath:
- signed (opcode 0) sign-fills everything above the field;
- insert (opcode 1) keeps the untouched bits of the existing destination value;
- unsigned (opcode 2) zero-fills.

The common extend and shift forms fall out of the general rule: byte, half and word extension, logical and arithmetic right shift, and left shift.

A second mode (mode = 1) gives signed or unsigned extraction on 32-bit operands. It takes an explicit least significant bit position and a width field that holds the width minus one. It is mapped onto the same datapath: R is the shift and S is shift + width − 1.

Operations enter on a valid/ready stream and leave one cycle later on a second valid/ready stream, together with an illegal-encoding flag. An input is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its result and flag unchanged and no new input is accepted.

Top module: `bfm_unit`

## Requirements
- R1: Unsigned move (mode 0, opcode 2) with S ≥ R puts source bits S..R at result bits (S−R)..0, and every other result bit is zero.
- R2: Signed move (mode 0, opcode 0) with S ≥ R puts the same field at bit 0 and copies source bit S into every result bit above the field, up to the operand size.
- R3: With S < R, the low S+1 source bits land at bit position size−R. An unsigned move leaves all other result bits zero.
- R4: A signed move with S < R fills with source bit S every bit from the top of the deposited field up to size−1. Bits below the field are zero.
- R5: An insert (opcode 1) writes the field exactly as R1/R3 place it. Every other bit below the operand size keeps the value of `in_dst`.
- R6: With `in_wide` = 0, only source and destination bits 31..0 are used, and result bits 63..32 are zero. Explicit mode always works this way.
- R7: In mode 0, opcode 3 is illegal, and so is `in_wide` = 0 with R ≥ 32 or S ≥ 32. An illegal operation gives `out_illegal` = 1 and a result of zero.
- R8: In explicit mode, the shift is `in_r` and the width is `in_s[4:0]`+1. Opcode 0 sign-extends and opcode 2 zero-extends the 32-bit field. Width 32 with shift 0 returns source bits 31..0 unchanged.
- R9: Explicit mode is illegal, with a zero result, when shift + width exceeds 32, when `in_s[5]` is 1, or when the opcode is 1 or 3.
- R10: An accepted input shows up with `out_valid` high at the next rising edge. `in_ready` equals not `out_valid` or `out_ready`. A stalled output holds its result and flag.
- R11: These forms come from the general rule, with no separate path:
  - S = 7, 15 or 31 with R = 0 gives byte, half or word extension.
  - S = size−1 gives a right shift by R, arithmetic for opcode 0 and logical for opcode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_mode | input | 1 | 0 = rotate/top-bit move, 1 = explicit shift/width extract |
| in_opc | input | 2 | 0 signed, 1 insert, 2 unsigned, 3 reserved |
| in_wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit (mode 0 only) |
| in_r | input | 6 | Rotate amount, or shift in explicit mode |
| in_s | input | 6 | Top-bit index, or width−1 in explicit mode |
| in_src | input | 64 | Source operand |
| in_dst | input | 64 | Existing destination value (insert) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Result word |
| out_illegal | output | 1 | Encoding was illegal; result is zero |

## Verification
Any fault in the rotate, the mask boundaries or the choice of fill policy shows up as a wrong result word in the same transfer that carries the operation. A scoreboard compares every transfer against a bit-by-bit model built from the requirements, so such a fault is caught at once. The position boundaries are targeted directly:
- the extract/deposit split at S = R and S = R−1;
- top-bit fills that reach exactly to the operand size;
- narrow operands with garbage in the upper source half.

A fault in the output register or the handshake shows up in one of three ways: a transfer goes missing, a stalled result changes, or `out_valid` is late by a cycle. The queue depth and the held-value checks expose each of these within a cycle of the fault.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

  typedef enum logic [1:0] {
    BF_SIGNED   = 2'd0,
    BF_INSERT   = 2'd1,
    BF_UNSIGNED = 2'd2,
    BF_RSVD     = 2'd3
  } bf_opc_e;

  // Decoded control for one operation, consumed by the datapath.
  typedef struct packed {
    logic       illegal;
    logic       wide;
    logic       do_sign;
    logic       do_insert;
    logic [5:0] rot_amt;
    logic [5:0] sign_idx;
    logic [6:0] pos;
    logic [6:0] top;
  } bf_ctrl_t;

endpackage

// File: rtl/bfm_mask_gen.sv
// Thermometer mask: bit i is set when i < cnt.
module bfm_mask_gen #(
  parameter int W     = 64,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [CNT_W-1:0] cnt,
  output logic [W-1:0]     mask
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mask[i] = (cnt > CNT_W'(i));
  end

endmodule

// File: rtl/bfm_rotator.sv
// Logarithmic rotate-right, one stage per amount bit.
module bfm_rotator #(
  parameter int W     = 64,
  parameter int AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     dout
);

  logic [W-1:0] stg [AMT_W+1];

  assign stg[0] = din;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = amt[k] ? {stg[k][SH-1:0], stg[k][W-1:SH]} : stg[k];
  end

  assign dout = stg[AMT_W];

endmodule

// File: rtl/bfm_decode.sv
// Turns mode/opcode/R/S into field position, field top and fill policy.
module bfm_decode
  import bfm_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = DATA_W / 2,
  parameter int AMT_W  = $clog2(DATA_W),
  parameter int CNT_W  = AMT_W + 1
) (
  input  logic             mode,
  input  logic [1:0]       opc,
  input  logic             wide,
  input  logic [AMT_W-1:0] r,
  input  logic [AMT_W-1:0] s,
  output bf_ctrl_t         ctrl
);

  localparam logic [CNT_W-1:0] N_WIDE   = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] N_NARROW = CNT_W'(HALF_W);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  bf_opc_e          op;
  logic             wide_eff;
  logic [CNT_W-1:0] n_sz;
  logic [CNT_W-1:0] r_ext;
  logic [CNT_W-1:0] s_ext;
  logic             bad;

  assign op    = bf_opc_e'(opc);
  assign r_ext = {1'b0, r};

  always_comb begin
    if (mode) begin
      // explicit extract: top index is shift + (width - 1)
      wide_eff = 1'b0;
      s_ext    = r_ext + {2'b00, s[AMT_W-2:0]};
      bad      = s[AMT_W-1]
               || ((op != BF_SIGNED) && (op != BF_UNSIGNED))
               || (s_ext >= N_NARROW);
    end else begin
      wide_eff = wide;
      s_ext    = {1'b0, s};
      bad      = (op == BF_RSVD) || (!wide && (r[AMT_W-1] || s[AMT_W-1]));
    end
  end

  assign n_sz = wide_eff ? N_WIDE : N_NARROW;

  always_comb begin
    ctrl           = '0;
    ctrl.illegal   = bad;
    ctrl.wide      = wide_eff;
    ctrl.do_sign   = (op == BF_SIGNED);
    ctrl.do_insert = (op == BF_INSERT);
    ctrl.rot_amt   = r;
    ctrl.sign_idx  = s_ext[AMT_W-1:0];
    if (s_ext >= r_ext) begin
      ctrl.pos = '0;
      ctrl.top = s_ext - r_ext + ONE;
    end else begin
      ctrl.pos = n_sz - r_ext;
      ctrl.top = n_sz - r_ext + s_ext + ONE;
    end
  end

endmodule

// File: rtl/bfm_unit.sv
// Bitfield move unit: decode, rotate, three masks, merge, output register.
module bfm_unit
  import bfm_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = DATA_W / 2,
  parameter int AMT_W  = $clog2(DATA_W),
  parameter int CNT_W  = AMT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_mode,
  input  logic [1:0]        in_opc,
  input  logic              in_wide,
  input  logic [AMT_W-1:0]  in_r,
  input  logic [AMT_W-1:0]  in_s,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_dst,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);

  localparam int NMASK = 3;  // 0: below field, 1: below field top, 2: operand size

  bf_ctrl_t          ctrl;
  logic [DATA_W-1:0] src_eff;
  logic [DATA_W-1:0] rot;
  logic [CNT_W-1:0]  mcnt [NMASK];
  logic [DATA_W-1:0] mvec [NMASK];
  logic [DATA_W-1:0] field_m;
  logic [DATA_W-1:0] fill_m;
  logic              sign_bit;
  logic [DATA_W-1:0] res_d;
  logic              accept;

  bfm_decode #(
    .DATA_W(DATA_W), .HALF_W(HALF_W), .AMT_W(AMT_W), .CNT_W(CNT_W)
  ) i_decode (
    .mode (in_mode),
    .opc  (in_opc),
    .wide (in_wide),
    .r    (in_r),
    .s    (in_s),
    .ctrl (ctrl)
  );

  // A narrow operand is duplicated so that the wide rotate yields a
  // 32-bit rotate in its low half.
  assign src_eff = ctrl.wide ? in_src : {in_src[HALF_W-1:0], in_src[HALF_W-1:0]};

  bfm_rotator #(.W(DATA_W), .AMT_W(AMT_W)) i_rot (
    .din  (src_eff),
    .amt  (ctrl.rot_amt),
    .dout (rot)
  );

  assign mcnt[0] = ctrl.pos;
  assign mcnt[1] = ctrl.top;
  assign mcnt[2] = ctrl.wide ? CNT_W'(DATA_W) : CNT_W'(HALF_W);

  for (genvar m = 0; m < NMASK; m++) begin : g_mask
    bfm_mask_gen #(.W(DATA_W), .CNT_W(CNT_W)) i_mask (
      .cnt  (mcnt[m]),
      .mask (mvec[m])
    );
  end

  assign field_m  = mvec[1] & ~mvec[0];
  assign fill_m   = mvec[2] & ~mvec[1];
  assign sign_bit = in_src[ctrl.sign_idx];

  always_comb begin
    res_d = rot & field_m;
    if (ctrl.do_insert) begin
      res_d = res_d | (in_dst & mvec[2] & ~field_m);
    end
    if (ctrl.do_sign && sign_bit) begin
      res_d = res_d | fill_m;
    end
    if (ctrl.illegal) begin
      res_d = '0;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= res_d;
      out_illegal <= ctrl.illegal;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/bfm_unit_chk.sv
module bfm_unit_chk #(
  parameter int DATA_W = 64,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_mode,
  input logic [1:0]        in_opc,
  input logic              in_wide,
  input logic [AMT_W-1:0]  in_s,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_illegal
);

  localparam int HALF_W = DATA_W / 2;

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal));

  p_accept_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_illegal_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_result == '0);

  p_narrow_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_mode || !in_wide) |=> out_result[DATA_W-1:HALF_W] == '0);

  p_rsvd_opc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_mode && in_opc == 2'd3 |=> out_illegal);

  p_explicit_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode && (in_opc[0] || in_s[AMT_W-1]) |=> out_illegal);

endmodule

bind bfm_unit bfm_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_bfm_unit_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_mode     (in_mode),
  .in_opc      (in_opc),
  .in_wide     (in_wide),
  .in_s        (in_s),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/test_bfm_unit.sv
`timescale 1ns/1ps
module test_bfm_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_mode = 1'b0;
  logic [1:0]  in_opc = 2'd0;
  logic        in_wide = 1'b0;
  logic [5:0]  in_r = '0;
  logic [5:0]  in_s = '0;
  logic [63:0] in_src = '0;
  logic [63:0] in_dst = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_illegal;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit stall_en = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        ill;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  bfm_unit i_bfm_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_opc(in_opc), .in_wide(in_wide), .in_r(in_r),
    .in_s(in_s), .in_src(in_src), .in_dst(in_dst), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_illegal(out_illegal)
  );

  // Bit-by-bit model written from the requirements; {illegal, result}.
  function automatic logic [64:0] ref_model(bit mode, int opc, bit wide, int r, int s,
                                            logic [63:0] src, logic [63:0] dst);
    logic [63:0] res = '0;
    int n;
    int w;
    int pos;
    if (mode) begin
      w = (s % 32) + 1;
      if (s > 31 || opc == 1 || opc == 3 || r + w > 32) return {1'b1, 64'd0};
      for (int i = 0; i < 32; i++) begin
        if (i < w) res[i] = src[r + i];
        else if (opc == 0) res[i] = src[r + w - 1];
      end
      return {1'b0, res};
    end
    if (opc == 3 || (!wide && (r > 31 || s > 31))) return {1'b1, 64'd0};
    n = wide ? 64 : 32;
    for (int i = 0; i < n; i++) begin
      if (s >= r) begin
        if (i <= s - r) res[i] = src[r + i];
        else if (opc == 0) res[i] = src[s];
        else if (opc == 1) res[i] = dst[i];
      end else begin
        pos = n - r;
        if (i >= pos && i <= pos + s) res[i] = src[i - pos];
        else if (opc == 0 && i > pos + s) res[i] = src[s];
        else if (opc == 1) res[i] = dst[i];
      end
    end
    return {1'b0, res};
  endfunction

  task automatic check(bit ok, string tag, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: called at a falling edge, returns at a falling edge.
  task automatic send(string tag, bit mode, int opc, bit wide, int r, int s,
                      logic [63:0] src, logic [63:0] dst);
    logic [64:0] e;
    exp_t it;
    e = ref_model(mode, opc, wide, r, s, src, dst);
    in_valid = 1'b1;
    in_mode  = mode;
    in_opc   = 2'(opc);
    in_wide  = wide;
    in_r     = 6'(r);
    in_s     = 6'(s);
    in_src   = src;
    in_dst   = dst;
    #3;
    while (!in_ready) begin
      @(negedge clk);
      #3;
    end
    it.res = e[63:0];
    it.ill = e[64];
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R10 latency", {64'd0, out_valid}, 65'd1);
  endtask

  // Output back-pressure pattern.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // Monitor / scoreboard.
  initial begin
    bit          held_prev = 1'b0;
    logic [64:0] held_val  = '0;
    exp_t        it;
    forever begin
      @(negedge clk);
      #4;
      if (rst_n) begin
        if (held_prev && out_valid)
          check({out_illegal, out_result} === held_val, "R10 stall hold",
                {out_illegal, out_result}, held_val);
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            check(1'b0, "R10 unexpected output", {out_illegal, out_result}, 65'd0);
          end else begin
            it = q.pop_front();
            check({out_illegal, out_result} === {it.ill, it.res}, it.tag,
                  {out_illegal, out_result}, {it.ill, it.res});
          end
        end
        held_prev = out_valid && !out_ready;
        held_val  = {out_illegal, out_result};
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [63:0] PAT = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] NEG = 64'h8123_4567_89AB_CDEF;

  initial begin
    logic [63:0] a;
    logic [63:0] b;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_result === 64'd0 && in_ready === 1'b1, "R10 reset state",
          {out_valid, out_result}, 65'd0);
    rst_n = 1'b1;
    @(negedge clk);

    send("R1 unsigned extract 15..8", 0, 2, 1, 8, 15, PAT, '0);
    send("R1 extract at S=R", 0, 2, 1, 9, 9, PAT, '0);
    send("R2 signed extract 11..4", 0, 0, 1, 4, 11, 64'h0000_0000_0000_0A50, '0);
    send("R2 signed extract positive", 0, 0, 1, 4, 11, 64'h0000_0000_0000_0250, '0);
    send("R3 deposit shift-left by 4", 0, 2, 1, 60, 3, PAT, '0);
    send("R3 deposit S=R-1", 0, 2, 1, 10, 9, PAT, '0);
    send("R4 signed deposit", 0, 0, 1, 16, 3, 64'h8, '0);
    send("R4 signed deposit full top", 0, 0, 1, 8, 7, 64'h80, '0);
    send("R5 insert extract", 0, 1, 1, 8, 15, PAT, '1);
    send("R5 insert deposit", 0, 1, 1, 56, 7, PAT, 64'h5555_5555_5555_5555);
    send("R6 narrow upper ignored", 0, 2, 0, 0, 31, 64'hDEAD_BEEF_1234_5678, '0);
    send("R6 narrow deposit", 0, 0, 0, 4, 1, 64'hFFFF_FFFF_0000_0002, 64'hFFFF_FFFF_FFFF_FFFF);
    send("R6 narrow insert", 0, 1, 0, 4, 3, PAT, 64'hFFFF_FFFF_FFFF_FFFF);
    send("R7 narrow R>=32", 0, 2, 0, 32, 3, PAT, '0);
    send("R7 narrow S>=32", 0, 0, 0, 1, 40, PAT, '0);
    send("R7 reserved opcode", 0, 3, 1, 1, 5, PAT, '0);
    send("R11 sign-extend byte", 0, 0, 1, 0, 7, 64'h0000_0000_0000_0080, '0);
    send("R11 sign-extend half", 0, 0, 1, 0, 15, 64'h1111_2222_3333_8001, '0);
    send("R11 sign-extend word", 0, 0, 1, 0, 31, NEG, '0);
    send("R11 zero-extend byte", 0, 2, 1, 0, 7, NEG, '0);
    send("R11 arithmetic shift", 0, 0, 1, 12, 63, NEG, '0);
    send("R11 logical shift", 0, 2, 1, 12, 63, NEG, '0);
    send("R11 narrow arithmetic shift", 0, 0, 0, 5, 31, 64'h0000_0000_F000_0000, '0);
    send("R8 explicit signed", 1, 0, 0, 4, 7, 64'h0000_0000_0000_0F80, '0);
    send("R8 explicit unsigned", 1, 2, 0, 4, 7, 64'h0000_0000_0000_0F80, '0);
    send("R8 explicit width 32", 1, 0, 0, 0, 31, NEG, '0);
    send("R8 explicit reaches bit 31", 1, 0, 0, 20, 11, NEG, '0);
    send("R9 explicit overflow", 1, 0, 0, 20, 12, NEG, '0);
    send("R9 explicit s5 set", 1, 2, 0, 0, 33, NEG, '0);
    send("R9 explicit insert opcode", 1, 1, 0, 0, 3, NEG, '0);

    stall_en = 1'b1;
    for (int k = 0; k < 300; k++) begin
      bit m;
      bit wd;
      int o;
      int rr;
      int ss;
      m  = (($urandom % 4) == 0);
      o  = $urandom % 4;
      wd = $urandom % 2;
      rr = (($urandom % 8) != 0) ? ($urandom % (wd ? 64 : 32)) : ($urandom % 64);
      ss = (($urandom % 8) != 0) ? ($urandom % (wd ? 64 : 32)) : ($urandom % 64);
      a  = {$urandom, $urandom};
      b  = {$urandom, $urandom};
      send("R10 random stream", m, o, wd, rr, ss, a, b);
    end

    stall_en = 1'b0;
    for (int k = 0; k < 1000 && q.size() != 0; k++) @(negedge clk);
    check(q.size() == 0, "R10 drained", 65'(q.size()), 65'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule